// File: doc/BRIEF.md
# Boundary-scan test access port

This block is a serial test port that sits around a small core. A tester drives four wires: a test clock, a mode-select line, serial data in and serial data out. Through them it walks a sixteen-state controller, loads an instruction, and then shifts data through whichever data register that instruction selects. The three data registers are a one-bit pass-through stage, a 32-bit identification word and a boundary register. The boundary register has one cell for each pin the core observes and one cell for each pin the core drives.

Four instructions are decoded. Two of them select the boundary register. The sample/preload instruction leaves the core in charge of its output pins and only takes snapshots or stages new values. The external-test instruction hands the output pins to the staged values, so the board wiring can be exercised without the core. An identification instruction exposes a fixed device word. Every other code routes data through the single pass-through bit, which keeps a long chain of such ports cheap to traverse.

The controller and all capture, shift and update registers advance on the rising test-clock edge. The serial output is retimed onto the falling edge. A synchronous active-high reset, sampled on the test clock, forces the controller into its reset state.

Top module: `scan_port`

## Requirements
- R1: Five consecutive rising test-clock edges with tms high bring the controller to the reset state from any state. Entering that state reloads the default instruction, which is IDCODE when the identification register is present.
- R2: In the instruction capture state, the instruction shift stage loads the value 1 in its low two bits (bit0 = 1, bit1 = 0) and zeros above. That value is the first IR_W bits seen on tdo, least significant first.
- R3: With the IDCODE instruction (code 2) latched, a data scan shifts out the 32-bit identification word, least significant bit first.
- R4: With the all-ones instruction latched, the data path is one bit long. The first bit out is 0, and every later bit out equals the tdi bit sampled one edge earlier.
- R5: Every instruction code other than 0, 1 and 2 (and code 2 when no identification register is built) behaves exactly as in R4.
- R6: With SAMPLE (code 1) latched, the capture state loads the boundary register with {pin_out, pin_in}. The input cells are the low NUM_IN bits and bit 0 is shifted out first. pin_out keeps following core_out throughout.
- R7: Values shifted and updated into the boundary register under SAMPLE appear on pin_out as soon as EXTEST (code 0) is latched by the instruction update, before any further data scan.
- R8: With EXTEST latched, the output cells drive pin_out. pin_out changes only on the edge that leaves the data update state, and holds steady through capture, shift and pause.
- R9: tdo_en is 1 exactly while the controller is in a shift state. Outside shift states tdo is 0. tdo changes on the falling edge of tck.
- R10: While rst is high at a rising edge, the controller enters the reset state, the instruction becomes the default, and the output update latches clear. pin_out then follows core_out.
- R11: When the block is built with HAS_IDCODE = 0, the default instruction after reset is the bypass path of R4.
- R12: A data shift can be suspended through the exit and pause states and resumed through the second exit state without losing or repeating a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; controller and scan registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset, sampled on tck |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data into the selected register |
| tdo | output | 1 | Serial data out, updated on the falling edge of tck |
| tdo_en | output | 1 | High while tdo carries shift data |
| pin_in | input | NUM_IN | Values seen on the core's input pins |
| core_out | input | NUM_OUT | Values the core wants on its output pins |
| pin_out | output | NUM_OUT | Values driven onto the output pins |

## Verification
The bench forces the controller into reset from the middle of a data shift and from an instruction pause. A controller that needs more than five ones, or that does not reload the default instruction, would then shift out the bypass pattern instead of the identification word. It preloads pin values under SAMPLE and then switches to EXTEST. A design that updated the output latches outside the update state, or that let core_out leak through under EXTEST, would show moving or wrong pins during the scan. It also walks every unused instruction code through the bypass check and suspends an identification scan halfway through a pause. Both catch a decoder without a fallback and a shift register that advances outside the shift state.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHIFT_DR,
        ST_EXIT1_DR,
        ST_PAUSE_DR,
        ST_EXIT2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHIFT_IR,
        ST_EXIT1_IR,
        ST_PAUSE_IR,
        ST_EXIT2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDCODE,
        PATH_BOUNDARY
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     drive_pins;
    } ir_decode_t;

    typedef struct packed {
        logic in_reset;
        logic cap_dr;
        logic shift_dr;
        logic upd_dr;
        logic cap_ir;
        logic shift_ir;
        logic upd_ir;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        unique case (s)
            ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   n = m ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: n = m ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: n = m ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: n = m ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   n = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   n = m ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: n = m ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: n = m ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: n = m ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   n = m ? ST_SEL_DR   : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic logic in_shift(input tap_state_e s);
        return (s == ST_SHIFT_DR) || (s == ST_SHIFT_IR);
    endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    always_ff @(posedge tck) begin
        if (rst) begin
            state <= ST_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

    // Strobes name the state whose leaving edge performs the action.
    always_comb begin
        ctl.in_reset = (state == ST_RESET);
        ctl.cap_dr   = (state == ST_CAP_DR);
        ctl.shift_dr = (state == ST_SHIFT_DR);
        ctl.upd_dr   = (state == ST_UPD_DR);
        ctl.cap_ir   = (state == ST_CAP_IR);
        ctl.shift_ir = (state == ST_SHIFT_IR);
        ctl.upd_ir   = (state == ST_UPD_IR);
    end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
#(
    parameter int              IR_W        = 4,
    parameter bit              HAS_IDCODE  = 1'b1,
    parameter logic [IR_W-1:0] CODE_EXTEST = '0,
    parameter logic [IR_W-1:0] CODE_SAMPLE = IR_W'(1),
    parameter logic [IR_W-1:0] CODE_IDCODE = IR_W'(2)
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            shift_ir,
    input  logic            upd_ir,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_shift,
    output ir_decode_t      dec
);

    localparam logic [IR_W-1:0] CODE_DEFAULT = HAS_IDCODE ? CODE_IDCODE : '1;
    localparam logic [IR_W-1:0] CAP_PATTERN  = IR_W'(1);

    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_shift <= '0;
            ir_q     <= CODE_DEFAULT;
        end else begin
            if (cap_ir) begin
                ir_shift <= CAP_PATTERN;
            end else if (shift_ir) begin
                ir_shift <= {tdi, ir_shift[IR_W-1:1]};
            end
            if (in_reset) begin
                ir_q <= CODE_DEFAULT;
            end else if (upd_ir) begin
                ir_q <= ir_shift;
            end
        end
    end

    always_comb begin
        dec.path       = PATH_BYPASS;
        dec.drive_pins = 1'b0;
        if (ir_q == CODE_EXTEST) begin
            dec.path       = PATH_BOUNDARY;
            dec.drive_pins = 1'b1;
        end else if (ir_q == CODE_SAMPLE) begin
            dec.path = PATH_BOUNDARY;
        end else if (HAS_IDCODE && (ir_q == CODE_IDCODE)) begin
            dec.path = PATH_IDCODE;
        end
    end

endmodule

// File: rtl/scan_bsr.sv
module scan_bsr #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               selected,
    input  logic               cap_dr,
    input  logic               shift_dr,
    input  logic               upd_dr,
    input  logic               drive_pins,
    input  logic               tdi,
    input  logic [NUM_IN-1:0]  pin_in,
    input  logic [NUM_OUT-1:0] core_out,
    output logic [NUM_OUT-1:0] pin_out,
    output logic               bsr_lsb
);

    localparam int LEN = NUM_IN + NUM_OUT;

    logic [LEN-1:0]     sh;
    logic [LEN-1:0]     cap_src;
    logic [LEN-1:0]     shift_src;
    logic [NUM_OUT-1:0] upd_out;

    assign pin_out = drive_pins ? upd_out : core_out;

    genvar gi;
    generate
        for (gi = 0; gi < LEN; gi++) begin : g_cell
            if (gi < NUM_IN) begin : g_in
                assign cap_src[gi] = pin_in[gi];
            end else begin : g_out
                assign cap_src[gi] = pin_out[gi-NUM_IN];
            end
            if (gi == LEN - 1) begin : g_head
                assign shift_src[gi] = tdi;
            end else begin : g_link
                assign shift_src[gi] = sh[gi+1];
            end
            always_ff @(posedge tck) begin
                if (rst) begin
                    sh[gi] <= 1'b0;
                end else if (selected && cap_dr) begin
                    sh[gi] <= cap_src[gi];
                end else if (selected && shift_dr) begin
                    sh[gi] <= shift_src[gi];
                end
            end
        end
    endgenerate

    always_ff @(posedge tck) begin
        if (rst) begin
            upd_out <= '0;
        end else if (selected && upd_dr) begin
            upd_out <= sh[LEN-1:NUM_IN];
        end
    end

    assign bsr_lsb = sh[0];

endmodule

// File: rtl/scan_port.sv
module scan_port
    import scan_pkg::*;
#(
    parameter int              IR_W        = 4,
    parameter int              NUM_IN      = 4,
    parameter int              NUM_OUT     = 4,
    parameter bit              HAS_IDCODE  = 1'b1,
    parameter logic [ID_W-1:0] ID_VALUE    = 32'h4B1D_E093,
    parameter logic [IR_W-1:0] CODE_EXTEST = '0,
    parameter logic [IR_W-1:0] CODE_SAMPLE = IR_W'(1),
    parameter logic [IR_W-1:0] CODE_IDCODE = IR_W'(2)
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_en,
    input  logic [NUM_IN-1:0]  pin_in,
    input  logic [NUM_OUT-1:0] core_out,
    output logic [NUM_OUT-1:0] pin_out
);

    tap_state_e      state;
    tap_ctl_t        ctl;
    ir_decode_t      dec;
    logic [IR_W-1:0] ir_shift;
    logic            bypass_q;
    logic            id_lsb;
    logic            bsr_lsb;
    logic            extest_on;
    logic            bsr_sel;
    logic            tdo_next;

    scan_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state),
        .ctl   (ctl)
    );

    scan_ir #(
        .IR_W        (IR_W),
        .HAS_IDCODE  (HAS_IDCODE),
        .CODE_EXTEST (CODE_EXTEST),
        .CODE_SAMPLE (CODE_SAMPLE),
        .CODE_IDCODE (CODE_IDCODE)
    ) u_ir (
        .tck      (tck),
        .rst      (rst),
        .in_reset (ctl.in_reset),
        .cap_ir   (ctl.cap_ir),
        .shift_ir (ctl.shift_ir),
        .upd_ir   (ctl.upd_ir),
        .tdi      (tdi),
        .ir_shift (ir_shift),
        .dec      (dec)
    );

    assign extest_on = dec.drive_pins;
    assign bsr_sel   = (dec.path == PATH_BOUNDARY);

    always_ff @(posedge tck) begin
        if (rst) begin
            bypass_q <= 1'b0;
        end else if ((dec.path == PATH_BYPASS) && ctl.cap_dr) begin
            bypass_q <= 1'b0;
        end else if ((dec.path == PATH_BYPASS) && ctl.shift_dr) begin
            bypass_q <= tdi;
        end
    end

    generate
        if (HAS_IDCODE) begin : g_id
            logic [ID_W-1:0] id_sh;
            always_ff @(posedge tck) begin
                if (rst) begin
                    id_sh <= '0;
                end else if ((dec.path == PATH_IDCODE) && ctl.cap_dr) begin
                    id_sh <= ID_VALUE;
                end else if ((dec.path == PATH_IDCODE) && ctl.shift_dr) begin
                    id_sh <= {tdi, id_sh[ID_W-1:1]};
                end
            end
            assign id_lsb = id_sh[0];
        end else begin : g_noid
            assign id_lsb = 1'b0;
        end
    endgenerate

    scan_bsr #(
        .NUM_IN  (NUM_IN),
        .NUM_OUT (NUM_OUT)
    ) u_bsr (
        .tck        (tck),
        .rst        (rst),
        .selected   (bsr_sel),
        .cap_dr     (ctl.cap_dr),
        .shift_dr   (ctl.shift_dr),
        .upd_dr     (ctl.upd_dr),
        .drive_pins (extest_on),
        .tdi        (tdi),
        .pin_in     (pin_in),
        .core_out   (core_out),
        .pin_out    (pin_out),
        .bsr_lsb    (bsr_lsb)
    );

    always_comb begin
        tdo_next = 1'b0;
        if (ctl.shift_ir) begin
            tdo_next = ir_shift[0];
        end else if (ctl.shift_dr) begin
            unique case (dec.path)
                PATH_IDCODE:   tdo_next = id_lsb;
                PATH_BOUNDARY: tdo_next = bsr_lsb;
                default:       tdo_next = bypass_q;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_next;
            tdo_en <= ctl.shift_ir | ctl.shift_dr;
        end
    end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int IR_W    = 4
) (
    input logic               tck,
    input logic               rst,
    input logic               tms,
    input tap_state_e         state,
    input logic               tdo_en,
    input logic               extest_on,
    input logic [NUM_OUT-1:0] pin_out,
    input logic [IR_W-1:0]    ir_shift
);

    logic [2:0] ones_run;

    always_ff @(posedge tck) begin
        if (rst) begin
            ones_run <= '0;
        end else if (tms) begin
            ones_run <= (ones_run == 3'd7) ? 3'd7 : ones_run + 3'd1;
        end else begin
            ones_run <= '0;
        end
    end

    a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (rst)
        (ones_run >= 3'd5) |-> (state == ST_RESET));

    a_r2_ir_capture: assert property (@(posedge tck) disable iff (rst)
        ($past(state) == ST_CAP_IR) |-> (ir_shift == IR_W'(1)));

    a_r8_pins_hold: assert property (@(posedge tck) disable iff (rst)
        (extest_on && $past(extest_on) && ($past(state) != ST_UPD_DR)) |-> $stable(pin_out));

    a_r9_tdo_en_shift: assert property (@(posedge tck) disable iff (rst)
        tdo_en == in_shift(state));

    a_r10_sync_reset: assert property (@(posedge tck)
        rst |=> (state == ST_RESET));

endmodule

bind scan_port scan_port_chk #(
    .NUM_OUT (NUM_OUT),
    .IR_W    (IR_W)
) u_chk (
    .tck       (tck),
    .rst       (rst),
    .tms       (tms),
    .state     (state),
    .tdo_en    (tdo_en),
    .extest_on (extest_on),
    .pin_out   (pin_out),
    .ir_shift  (ir_shift)
);

// File: tb/scan_port_bench.sv
module scan_port_bench;

    localparam int PERIOD  = 10;
    localparam int IR_W    = 4;
    localparam int NUM_IN  = 4;
    localparam int NUM_OUT = 4;
    localparam int BSR_LEN = NUM_IN + NUM_OUT;
    localparam logic [31:0] ID_WORD = 32'h4B1D_E093;
    localparam logic [IR_W-1:0] OP_EXTEST = 4'd0;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'd1;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'd2;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [NUM_IN-1:0]  pin_in   = '0;
    logic [NUM_OUT-1:0] core_out = '0;
    logic tdo, tdo_en, tdo2, tdo_en2;
    logic [NUM_OUT-1:0] pin_out, pin_out2;

    int checks = 0;
    int fails  = 0;

    logic s_tdo, s_tdo2, s_en;
    logic [NUM_OUT-1:0] s_pins;
    logic [63:0] so, so2;
    bit en_bad, moved;

    scan_port #(.IR_W(IR_W), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT),
                .HAS_IDCODE(1'b1), .ID_VALUE(ID_WORD)) u_scan_port (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pin_in(pin_in), .core_out(core_out), .pin_out(pin_out));

    scan_port #(.IR_W(IR_W), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT),
                .HAS_IDCODE(1'b0)) u_scan_port_noid (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo2), .tdo_en(tdo_en2),
        .pin_in(pin_in), .core_out(core_out), .pin_out(pin_out2));

    initial forever #(PERIOD/2) tck = ~tck;

    function automatic logic [63:0] low_mask(input int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [63:0] bypass_expect(input logic [63:0] din, input int n);
        return (din << 1) & low_mask(n);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        s_tdo  = tdo;
        s_tdo2 = tdo2;
        s_en   = tdo_en;
        s_pins = pin_out;
        tms = m;
        tdi = d;
    endtask

    // Returns with the controller heading to idle on the next edge.
    task automatic scan_ir(input logic [IR_W-1:0] code, output logic [IR_W-1:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < IR_W; i++) begin
            step(i == IR_W - 1, code[i]);
            cap[i] = s_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, input int pause_at);
        logic [NUM_OUT-1:0] first;
        so = '0; so2 = '0; en_bad = 0; moved = 0;
        step(1, 0);
        first = s_pins;
        step(0, 0);
        if (s_pins !== first) moved = 1;
        step(0, 0);
        if (s_pins !== first) moved = 1;
        for (int i = 0; i < n; i++) begin
            step((i == n - 1) || (pause_at > 0 && i == pause_at - 1), din[i]);
            so[i]  = s_tdo;
            so2[i] = s_tdo2;
            if (s_en !== 1'b1) en_bad = 1;
            if (s_pins !== first) moved = 1;
            if (pause_at > 0 && i == pause_at - 1) begin
                step(0, 0);
                if (s_en !== 1'b0 || s_tdo !== 1'b0) en_bad = 1;
                step(0, 0);
                if (s_en !== 1'b0 || s_tdo !== 1'b0) en_bad = 1;
                step(1, 0);
                if (s_en !== 1'b0) en_bad = 1;
                step(0, 0);
                if (s_en !== 1'b0) en_bad = 1;
                if (s_pins !== first) moved = 1;
            end
        end
        step(1, 0);
        if (s_pins !== first) moved = 1;
        step(0, 0);
        if (s_pins !== first) moved = 1;
    endtask

    initial begin
        #(PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [IR_W-1:0] cap;
        logic [63:0] din;
        logic [BSR_LEN-1:0] pre;
        logic [NUM_OUT-1:0] settled;
        void'($urandom(32'h5EED_0042));

        // R10: reset state
        core_out = 4'hA;
        repeat (3) @(negedge tck);
        #1;
        check(tdo_en == 1'b0 && tdo == 1'b0, "R10 tdo idle in reset", {tdo_en, tdo}, 0);
        check(pin_out == core_out, "R10 pins follow core in reset", pin_out, core_out);
        rst = 1'b0;
        step(0, 0);
        step(0, 0);
        check(s_en == 1'b0 && s_tdo == 1'b0, "R9 tdo quiet in idle", {s_en, s_tdo}, 0);

        // R3 and R11: default instruction after reset
        din = {32'h0, $urandom()};
        scan_dr(32, din, 0);
        check(so[31:0] == ID_WORD, "R3 identification word", so[31:0], ID_WORD);
        check(so2[31:0] == bypass_expect(din, 32), "R11 no-id default is bypass",
              so2[31:0], bypass_expect(din, 32));
        check(!en_bad, "R9 tdo_en during shift", en_bad, 0);

        // R2: capture pattern of the instruction register
        scan_ir(OP_BYPASS, cap);
        check(cap == 4'b0001, "R2 instruction capture", cap, 4'b0001);

        // R4: bypass under random data
        for (int k = 0; k < 4; k++) begin
            din = {$urandom(), $urandom()};
            scan_dr(20, din, 0);
            check(so[19:0] == bypass_expect(din, 20), "R4 bypass one-bit delay",
                  so[19:0], bypass_expect(din, 20));
        end

        // R5: every unused code falls back to bypass
        for (int c = 3; c < 15; c++) begin
            scan_ir(c[IR_W-1:0], cap);
            check(cap == 4'b0001, "R2 instruction capture", cap, 4'b0001);
            din = {32'h0, $urandom()};
            scan_dr(10, din, 0);
            check(so[9:0] == bypass_expect(din, 10), "R5 unused code acts as bypass",
                  so[9:0], bypass_expect(din, 10));
        end

        // R6: sample snapshot while the core keeps the pins
        pin_in   = 4'h6;
        core_out = 4'hC;
        scan_ir(OP_SAMPLE, cap);
        pre = 8'h3A;
        scan_dr(BSR_LEN, {56'h0, pre}, 0);
        check(so[7:0] == {core_out, pin_in}, "R6 sample capture", so[7:0], {core_out, pin_in});
        step(0, 0);
        check(pin_out == core_out, "R6 pins follow core under sample", pin_out, core_out);
        core_out = 4'h5;
        step(0, 0);
        check(pin_out == 4'h5, "R6 pins track core change", pin_out, 4'h5);

        // R7: preloaded values appear once EXTEST is latched
        core_out = ~pre[7:4];
        scan_ir(OP_EXTEST, cap);
        step(0, 0);
        check(pin_out == pre[7:4], "R7 preload drives pins", pin_out, pre[7:4]);
        settled = pre[7:4];

        // R8: extest capture, shift stability and update
        for (int k = 0; k < 4; k++) begin
            pin_in   = 4'($urandom());
            core_out = 4'($urandom());
            din = {56'h0, 8'($urandom())};
            scan_dr(BSR_LEN, din, 0);
            check(so[7:0] == {settled, pin_in}, "R8 extest capture", so[7:0], {settled, pin_in});
            check(!moved, "R8 pins hold during scan", moved, 0);
            step(0, 0);
            check(pin_out == din[7:4], "R8 update drives pins", pin_out, din[7:4]);
            settled = din[7:4];
        end

        // R1: five ones from the middle of a data shift
        scan_ir(OP_BYPASS, cap);
        step(1, 0); step(0, 0); step(0, 0); step(0, 1);
        for (int k = 0; k < 5; k++) step(1, 0);
        step(0, 0);
        check(pin_out == core_out, "R1 reset releases pins", pin_out, core_out);
        scan_dr(32, 64'h0, 0);
        check(so[31:0] == ID_WORD, "R1 reset from shift reloads idcode", so[31:0], ID_WORD);

        // R1: five ones from the instruction pause state
        scan_ir(OP_BYPASS, cap);
        step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < 5; k++) step(1, 0);
        step(0, 0);
        scan_dr(32, 64'h0, 0);
        check(so[31:0] == ID_WORD, "R1 reset from ir pause reloads idcode", so[31:0], ID_WORD);

        // R12: identification scan suspended in pause
        scan_ir(OP_IDCODE, cap);
        scan_dr(32, {32'h0, $urandom()}, 16);
        check(so[31:0] == ID_WORD, "R12 pause keeps bit order", so[31:0], ID_WORD);
        check(!en_bad, "R9 tdo_en low outside shift", en_bad, 0);

        // R10: synchronous reset mid-extest clears the latches
        scan_ir(OP_EXTEST, cap);
        scan_dr(BSR_LEN, 64'hF0, 0);
        step(0, 0);
        check(pin_out == 4'hF, "R8 update before reset", pin_out, 4'hF);
        core_out = 4'h9;
        rst = 1'b1;
        step(0, 0);
        step(0, 0);
        check(pin_out == 4'h9, "R10 reset returns pins to core", pin_out, 4'h9);
        rst = 1'b0;
        step(0, 0);
        scan_ir(OP_EXTEST, cap);
        step(0, 0);
        check(pin_out == 4'h0, "R10 reset cleared update latches", pin_out, 4'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule